// File: doc/BRIEF.md
# Dual-Bank Mixed-Trigger Interrupt Controller

This block collects 64 synchronous interrupt inputs into two 32-bit banks and drives one interrupt line to a single CPU. Each bank keeps a sticky event word, a software-written enable word, a live copy of the input levels, and a fixed selector that marks which bit positions are level-type rather than edge-type. Edge-type inputs latch an event when they rise, and the event stays until software acknowledges it. Level-type inputs never latch an event; they request service only while the input is high.

Software reaches the banks through a small 32-bit register bus with a 12-bit byte address. Bank 0 sits in the slot at 0x010 and bank 1 in the slot at 0x020. The inputs map onto the banks in reverse: inputs 0 to 31 feed bank 1 and inputs 32 to 63 feed bank 0. The output is the OR over both banks of the enabled, pending bits. It is computed straight from registered state, so it follows any state change on the next clock edge.

Top module: `twin_bank_intc`

## Requirements
- R1: After reset the events, enable and level words of both banks are zero, `cpu_irq` is 0 and `reg_rdata` is 0.
- R2: Bank b answers when `reg_addr[11:4]` equals b+1. Within a slot, low nibble 0x0 reads events, 0x4 reads and writes the enable word, and 0xC reads levels. A read returns its data on `reg_rdata` one cycle after `reg_rd` and holds it until the next read.
- R3: Input k drives bank 1-(k/32) at bit k mod 32. The level bit copies the input at every clock edge.
- R4: An edge-type bit sets its event bit when the input rises, that is high now with the stored level 0. Dropping the input leaves the event set.
- R5: Level-type bits never set an event bit. With default parameters these are bank 1 bits 20 to 28 (mask 0x1FF00000). Bank 0 has none.
- R6: A write to low nibble 0x8 clears each event bit written as 1, except the level-type bits. This acknowledge location reads as zero.
- R7: When an input rises in the same cycle as an acknowledge of its bit, the event bit stays set.
- R8: A read of any other slot, or of any low nibble other than 0x0, 0x4 or 0xC, returns zero. Writes to those locations change nothing.
- R9: `cpu_irq` is 1 exactly when some bank has a nonzero ((events OR (levels AND level-type)) AND enable).
- R10: An enable-word write takes effect at its clock edge, and `cpu_irq` reflects it from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 12 | Byte address within the 4 KB register window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_in | input | 64 | Synchronous interrupt inputs |
| cpu_irq | output | 1 | Combined interrupt request to the CPU |

## Verification
The bench targets the reversed input-to-bank mapping. A design that maps the inputs straight through shows the bank 0 input in bank 1's level word. It checks that an acknowledge cannot clear a level-type source: a design that skips this filter drops `cpu_irq` while the input is still high. It also checks that an event outlives its input, and that a rising input beats a same-cycle acknowledge; a design wrong on either loses an event. Unmapped slots and offsets must read zero and must not change the enable words, so loose address decoding shows up as altered data when the words are read back.

// File: rtl/twin_intc_pkg.sv
package twin_intc_pkg;

  // Low address nibble selecting a word inside a bank slot
  localparam logic [3:0] OFF_EVT = 4'h0;
  localparam logic [3:0] OFF_MSK = 4'h4;
  localparam logic [3:0] OFF_ACK = 4'h8;
  localparam logic [3:0] OFF_LVL = 4'hC;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_EVT,
    FLD_MSK,
    FLD_ACK,
    FLD_LVL
  } fld_e;

endpackage

// File: rtl/intc_src_router.sv
module intc_src_router #(
  parameter int NB = 2,
  parameter int BW = 32
) (
  input  logic [NB*BW-1:0]        src_flat,
  output logic [NB-1:0][BW-1:0]   bank_src
);

  // Input k lands in bank (NB-1 - k/BW) at bit k%BW
  for (genvar k = 0; k < NB*BW; k++) begin : g_map
    localparam int BANK = NB - 1 - (k / BW);
    localparam int BIT  = k % BW;
    assign bank_src[BANK][BIT] = src_flat[k];
  end

endmodule

// File: rtl/intc_reg_decode.sv
module intc_reg_decode
  import twin_intc_pkg::*;
#(
  parameter int NB = 2,
  parameter int AW = 12
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output logic [NB-1:0] mask_we,
  output logic [NB-1:0] ack_we,
  output logic [NB-1:0] rd_sel,
  output fld_e          rd_fld
);

  localparam int SLOT_W = AW - 4;

  logic [NB-1:0] hit;
  fld_e          fld;

  always_comb begin
    unique case (addr[3:0])
      OFF_EVT: fld = FLD_EVT;
      OFF_MSK: fld = FLD_MSK;
      OFF_ACK: fld = FLD_ACK;
      OFF_LVL: fld = FLD_LVL;
      default: fld = FLD_NONE;
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_slot
    assign hit[b]     = (addr[AW-1:4] == SLOT_W'(b + 1));
    assign mask_we[b] = wr & hit[b] & (fld == FLD_MSK);
    assign ack_we[b]  = wr & hit[b] & (fld == FLD_ACK);
    assign rd_sel[b]  = rd & hit[b] &
                        ((fld == FLD_EVT) | (fld == FLD_MSK) | (fld == FLD_LVL));
  end

  assign rd_fld = fld;

endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int            BW       = 32,
  parameter logic [BW-1:0] LVL_TYPE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] src,
  input  logic          mask_we,
  input  logic          ack_we,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] evt,
  output logic [BW-1:0] mask,
  output logic [BW-1:0] lvl,
  output logic          pending
);

  logic [BW-1:0] evt_q, evt_nxt;
  logic [BW-1:0] mask_q;
  logic [BW-1:0] lvl_q, lvl_nxt;
  logic [BW-1:0] rise;
  logic [BW-1:0] clr;

  // Next state
  always_comb begin
    rise    = src & ~lvl_q & ~LVL_TYPE;
    clr     = ack_we ? (wdata & ~LVL_TYPE) : '0;
    evt_nxt = (evt_q & ~clr) | rise;   // rise wins over acknowledge
    lvl_nxt = src;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      lvl_q <= '0;
    end else begin
      evt_q <= evt_nxt;
      lvl_q <= lvl_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= wdata;
    end
  end

  assign evt     = evt_q;
  assign mask    = mask_q;
  assign lvl     = lvl_q;
  assign pending = |((evt_q | (lvl_q & LVL_TYPE)) & mask_q);

  AST_LVL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_q == $past(src)));                                   // R3
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_we |=> ((evt_q & $past(evt_q)) == $past(evt_q)));             // R4
  AST_LVL_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & LVL_TYPE) == '0);                                         // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((evt_q & $past(wdata & ~LVL_TYPE & ~(src & ~lvl_q))) == '0)); // R6
  AST_RISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((evt_q & $past(src & ~lvl_q & ~LVL_TYPE)) == $past(src & ~lvl_q & ~LVL_TYPE))); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));                                     // R8

endmodule

// File: rtl/twin_bank_intc.sv
module twin_bank_intc
  import twin_intc_pkg::*;
#(
  parameter int                 NB       = 2,
  parameter int                 BW       = 32,
  parameter int                 AW       = 12,
  parameter logic [NB*BW-1:0]   LVL_TYPE = {32'h1FF0_0000, 32'h0000_0000}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [BW-1:0]    reg_wdata,
  input  logic             reg_rd,
  output logic [BW-1:0]    reg_rdata,
  input  logic [NB*BW-1:0] irq_in,
  output logic             cpu_irq
);

  // Reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_s2;

  logic [NB-1:0][BW-1:0] bank_src;
  logic [NB-1:0][BW-1:0] evt, mask, lvl;
  logic [NB-1:0]         pend;
  logic [NB-1:0]         mask_we, ack_we, rd_sel;
  fld_e                  rd_fld;

  intc_src_router #(.NB(NB), .BW(BW)) u_router (
    .src_flat (irq_in),
    .bank_src (bank_src)
  );

  intc_reg_decode #(.NB(NB), .AW(AW)) u_dec (
    .addr    (reg_addr),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .mask_we (mask_we),
    .ack_we  (ack_we),
    .rd_sel  (rd_sel),
    .rd_fld  (rd_fld)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    intc_bank #(.BW(BW), .LVL_TYPE(LVL_TYPE[b*BW +: BW])) u_bank (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .src     (bank_src[b]),
      .mask_we (mask_we[b]),
      .ack_we  (ack_we[b]),
      .wdata   (reg_wdata),
      .evt     (evt[b]),
      .mask    (mask[b]),
      .lvl     (lvl[b]),
      .pending (pend[b])
    );
  end

  // Read path: next value then enabled register
  logic [BW-1:0] rd_nxt, rdata_q;
  always_comb begin
    rd_nxt = '0;
    for (int b = 0; b < NB; b++) begin
      if (rd_sel[b]) begin
        unique case (rd_fld)
          FLD_EVT: rd_nxt = rd_nxt | evt[b];
          FLD_MSK: rd_nxt = rd_nxt | mask[b];
          FLD_LVL: rd_nxt = rd_nxt | lvl[b];
          default: rd_nxt = rd_nxt;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= rd_nxt;
    end
  end

  assign reg_rdata = rdata_q;
  assign cpu_irq   = |pend;

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_rd && (rd_sel == '0)) |=> (reg_rdata == '0));                 // R8
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({mask_we, ack_we}));                                      // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !reg_rd |=> $stable(reg_rdata));                                   // R2
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_irq |-> (mask != '0));                                         // R9

endmodule

// File: tb/sim_twin_bank_intc.sv
module sim_twin_bank_intc;

  localparam logic [11:0] B0 = 12'h010;
  localparam logic [11:0] B1 = 12'h020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [63:0] irq_in = '0;
  logic        cpu_irq;

  always #2 clk = ~clk;

  twin_bank_intc u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq_in(irq_in), .cpu_irq(cpu_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issue a read, push the expected word
  task automatic do_rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    reg_rd   = 1'b1;
    sb.push_back('{exp, tag});
    @(negedge clk);
    reg_rd   = 1'b0;
  endtask

  task automatic do_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic set_in(int k, logic v);
    @(negedge clk);
    irq_in[k] = v;
    @(negedge clk);
  endtask

  // Monitor: compare read data one cycle after the strobe
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd === 1'b1) begin
        item_t it;
        @(negedge clk);
        it = sb.pop_front();
        chk(it.tag, reg_rdata, it.exp);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
    chk("R1 rdata", reg_rdata, 32'h0);
    do_rd(B0 | 12'h0, 32'h0, "R1 b0 events");
    do_rd(B0 | 12'h4, 32'h0, "R1 b0 mask");
    do_rd(B1 | 12'hC, 32'h0, "R1 b1 levels");

    // R3/R4: input 35 -> bank 0 bit 3
    set_in(35, 1'b1);
    do_rd(B0 | 12'hC, 32'h8, "R3 b0 levels");
    do_rd(B1 | 12'hC, 32'h0, "R3 b1 levels untouched");
    do_rd(B0 | 12'h0, 32'h8, "R4 b0 event");
    chk("R9 masked off", {31'b0, cpu_irq}, 32'h0);

    // R10 enable write
    do_wr(B0 | 12'h4, 32'h8);
    chk("R10 irq after mask", {31'b0, cpu_irq}, 32'h1);
    do_rd(B0 | 12'h4, 32'h8, "R2 mask readback");
    repeat (2) @(negedge clk);
    chk("R2 rdata held", reg_rdata, 32'h8);

    // R4 event outlives input
    set_in(35, 1'b0);
    do_rd(B0 | 12'hC, 32'h0, "R3 b0 level dropped");
    do_rd(B0 | 12'h0, 32'h8, "R4 event sticky");
    chk("R4 irq still up", {31'b0, cpu_irq}, 32'h1);

    // R6 acknowledge
    do_wr(B0 | 12'h8, 32'h8);
    chk("R6 irq after ack", {31'b0, cpu_irq}, 32'h0);
    do_rd(B0 | 12'h0, 32'h0, "R6 event cleared");
    do_rd(B0 | 12'h8, 32'h0, "R6 ack reads zero");

    // R5 level-type source: input 20 -> bank 1 bit 20
    set_in(20, 1'b1);
    do_rd(B1 | 12'hC, 32'h0010_0000, "R3 b1 level bit20");
    do_rd(B1 | 12'h0, 32'h0, "R5 no event for level type");
    do_wr(B1 | 12'h4, 32'h0010_0000);
    chk("R9 level source raises irq", {31'b0, cpu_irq}, 32'h1);
    do_wr(B1 | 12'h8, 32'h0010_0000);
    chk("R6 ack cannot clear level", {31'b0, cpu_irq}, 32'h1);
    set_in(20, 1'b0);
    chk("R9 level source gone", {31'b0, cpu_irq}, 32'h0);

    // R3 edge in bank 1: input 0 -> bank 1 bit 0
    set_in(0, 1'b1);
    do_rd(B1 | 12'h0, 32'h1, "R3 input0 to bank1 bit0");
    chk("R9 unmasked event ignored", {31'b0, cpu_irq}, 32'h0);

    // R7 rise and acknowledge in the same cycle: input 33 -> bank 0 bit 1
    @(negedge clk);
    irq_in[33] = 1'b1;
    reg_addr   = B0 | 12'h8;
    reg_wdata  = 32'h2;
    reg_wr     = 1'b1;
    @(negedge clk);
    reg_wr     = 1'b0;
    do_rd(B0 | 12'h0, 32'h2, "R7 rise beats ack");
    do_wr(B0 | 12'h8, 32'h2);
    do_rd(B0 | 12'h0, 32'h0, "R6 later ack clears");

    // R8 unmapped locations
    do_wr(12'h034, 32'hFFFF_FFFF);
    do_wr(12'h004, 32'hFFFF_FFFF);
    do_wr(B0 | 12'h5, 32'hFFFF_FFFF);
    do_wr(B1 | 12'h0, 32'hFFFF_FFFF);
    do_rd(B0 | 12'h4, 32'h8, "R8 b0 mask untouched");
    do_rd(B1 | 12'h4, 32'h0010_0000, "R8 b1 mask untouched");
    do_rd(B1 | 12'h0, 32'h1, "R8 event write ignored");
    do_rd(12'h030, 32'h0, "R8 slot 3 reads zero");
    do_rd(12'h110, 32'h0, "R8 high slot reads zero");
    do_rd(B0 | 12'h2, 32'h0, "R8 odd offset reads zero");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule